// File: doc/BRIEF.md
# Encapsulation Stream Single-Byte Error Injector

This block sits inline on the byte-wide output of a frame encapsulator and deliberately corrupts exactly one byte when asked to. That byte is used to test the error detection further down the line. Each incoming byte carries a sideband tag that names its field and gives its index inside that field. The fields are:

- the 4-byte core header (two length bytes followed by two header-check bytes),
- the payload,
- the 4-byte Ethernet FCS,
- the 4-byte encapsulation FCS.

Every byte leaves the block one register stage later, with its valid and tags unchanged. The only byte that differs is the one chosen for corruption.

Software, or a test sequencer, sets a per-field enable mask, a 2-bit byte selector and an 8-bit XOR pattern. It then raises a trigger bit. Each 0-to-1 edge of the trigger arms one request. The request stays pending until the first enabled field byte whose index matches goes past. That byte is XORed with the pattern, and the request is consumed. In the payload only the first byte can be hit, whatever the selector holds.

Top module: `enc_err_inject`

## Requirements
- R1: Each input beat appears on the outputs exactly one cycle later with valid, field tag, index and data unchanged, unless that beat is the one selected for corruption.
- R2: A 0-to-1 transition of `trig` seen on a clock edge arms one request. The request can hit beats presented from the next cycle onward.
- R3: Field codes are 0 = core header, 1 = payload, 2 = Ethernet FCS, 3 = encapsulation FCS, and `field_en[k]` enables field code k. For codes 0, 2 and 3, the beat whose index equals `byte_sel` is the one hit.
- R4: In the payload (code 1) only the beat with index 0 can be hit, and `byte_sel` has no effect there.
- R5: A hit beat leaves as input data XOR `err_pat`, where the pattern is the value present in the cycle the beat enters.
- R6: Keeping `trig` at 1 yields exactly one corrupted beat, however many frames follow.
- R7: After `trig` returns to 0, a new 0-to-1 transition arms a new request.
- R8: When several fields are enabled, the first matching beat in stream order consumes the request, so only one beat is corrupted.
- R9: An all-zero pattern consumes the request without changing any data. Later matching beats pass unchanged until the next transition.
- R10: A pending request persists across beats and frames that do not match, for example while no field is enabled.
- R11: Synchronous active-high `rst` clears the pending request, the stored previous trigger and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Input byte |
| in_field | input | 2 | Field tag of the input beat |
| in_idx | input | IDX_W | Byte index within the field |
| field_en | input | 4 | Per-field injection enables, bit k for field code k |
| byte_sel | input | 2 | Byte index to hit in 4-byte fields |
| err_pat | input | DATA_W | XOR pattern |
| trig | input | 1 | Trigger; each rising edge arms one request |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output byte, possibly corrupted |
| out_field | output | 2 | Delayed field tag |
| out_idx | output | IDX_W | Delayed byte index |

## Verification
Two timings matter. A beat driven in one cycle is due on the outputs in the next cycle. A trigger edge driven in one cycle can only affect beats presented in the following cycle or later. The driver pushes each beat's expected value when it drives the beat. It sets its own pending flag only on the cycle it raises the trigger from 0, and no beat is driven in that cycle. The monitor then pops one expected item for every output beat, half a clock later than the edge where the beat leaves the block. At the end the queue must be empty, which shows that no beat was lost or added.

// File: rtl/encinj_pkg.sv
package encinj_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int FLD_W      = 2;
    localparam int SEL_W      = 2;

    typedef enum logic [FLD_W-1:0] {
        FLD_HDR  = 2'd0,
        FLD_PAY  = 2'd1,
        FLD_EFCS = 2'd2,
        FLD_XFCS = 2'd3
    } field_e;

    // Payload is locked to its first byte; other fields honour the selector.
    function automatic logic uses_selector(input field_e f);
        return f != FLD_PAY;
    endfunction

endpackage

// File: rtl/encinj_arm.sv
module encinj_arm (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic hit,
    output logic trig_prev,
    output logic pend
);
    logic rise;

    assign rise = trig & ~trig_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_prev <= 1'b0;
            pend      <= 1'b0;
        end else begin
            trig_prev <= trig;
            pend      <= rise | (pend & ~hit);
        end
    end
endmodule

// File: rtl/encinj_match.sv
module encinj_match
    import encinj_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                  in_valid,
    input  logic [FLD_W-1:0]      in_field,
    input  logic [IDX_W-1:0]      in_idx,
    input  logic [NUM_FIELDS-1:0] field_en,
    input  logic [SEL_W-1:0]      byte_sel,
    output logic                  match
);
    logic [NUM_FIELDS-1:0] fld_hit;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam field_e FCODE = field_e'(g);
        logic [IDX_W-1:0] want;
        assign want       = uses_selector(FCODE) ? IDX_W'(byte_sel) : '0;
        assign fld_hit[g] = field_en[g] && (in_field == FCODE) && (in_idx == want);
    end

    assign match = in_valid && (|fld_hit);
endmodule

// File: rtl/encinj_xor_stage.sv
module encinj_xor_stage
    import encinj_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [FLD_W-1:0]  in_field,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic              hit,
    input  logic [DATA_W-1:0] err_pat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [FLD_W-1:0]  out_field,
    output logic [IDX_W-1:0]  out_idx
);
    logic [DATA_W-1:0] mask;

    assign mask = hit ? err_pat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_field <= '0;
            out_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data ^ mask;
            out_field <= in_field;
            out_idx   <= in_idx;
        end
    end
endmodule

// File: rtl/enc_err_inject.sv
module enc_err_inject
    import encinj_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [FLD_W-1:0]      in_field,
    input  logic [IDX_W-1:0]      in_idx,
    input  logic [NUM_FIELDS-1:0] field_en,
    input  logic [SEL_W-1:0]      byte_sel,
    input  logic [DATA_W-1:0]     err_pat,
    input  logic                  trig,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic [FLD_W-1:0]      out_field,
    output logic [IDX_W-1:0]      out_idx
);
    logic match;
    logic pend;
    logic hit;
    logic trig_prev;

    assign hit = pend & match;

    encinj_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .hit       (hit),
        .trig_prev (trig_prev),
        .pend      (pend)
    );

    encinj_match #(.IDX_W(IDX_W)) u_match (
        .in_valid (in_valid),
        .in_field (in_field),
        .in_idx   (in_idx),
        .field_en (field_en),
        .byte_sel (byte_sel),
        .match    (match)
    );

    encinj_xor_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_xor (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_field  (in_field),
        .in_idx    (in_idx),
        .hit       (hit),
        .err_pat   (err_pat),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_field (out_field),
        .out_idx   (out_idx)
    );
endmodule

// File: rtl/enc_err_inject_chk.sv
module enc_err_inject_chk #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              trig,
    input logic              trig_prev,
    input logic              pend,
    input logic              hit,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [1:0]        in_field,
    input logic [IDX_W-1:0]  in_idx,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        out_field,
    input logic [IDX_W-1:0]  out_idx
);
    // R1: valid and tags follow the input one cycle later
    a_r1_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid) && out_field == $past(in_field)
                  && out_idx == $past(in_idx)));

    // R1 / R5: data can change only on a hit beat
    a_r5_only_hit_changes: assert property (@(posedge clk) disable iff (rst)
        !hit |=> out_data == $past(in_data));

    // R6 / R8: a consumed request is gone unless a new edge arrives
    a_r8_consume: assert property (@(posedge clk) disable iff (rst)
        (hit && !(trig && !trig_prev)) |=> !pend);

    // R6 / R7: without a fresh edge, nothing becomes pending
    a_r6_no_rearm: assert property (@(posedge clk) disable iff (rst)
        (!pend && !(trig && !trig_prev)) |=> !pend);

    // R10: a pending request without a hit stays pending
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (pend && !hit) |=> pend);

    // R2: an edge always leaves a pending request
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (trig && !trig_prev) |=> pend);
endmodule

bind enc_err_inject enc_err_inject_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .trig_prev (trig_prev),
    .pend      (pend),
    .hit       (hit),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_field  (in_field),
    .in_idx    (in_idx),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_field (out_field),
    .out_idx   (out_idx)
);

// File: tb/sim_enc_err_inject.sv
module sim_enc_err_inject;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic [1:0]        in_field;
    logic [IDX_W-1:0]  in_idx;
    logic [3:0]        field_en;
    logic [1:0]        byte_sel;
    logic [DATA_W-1:0] err_pat;
    logic              trig;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic [1:0]        out_field;
    logic [IDX_W-1:0]  out_idx;

    always #2.5 clk = ~clk;

    enc_err_inject #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u0 (.*);

    typedef struct {
        logic [DATA_W-1:0] data;
        logic [1:0]        fld;
        logic [IDX_W-1:0]  idx;
        string             req;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   model_pend = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference rule written from the requirements (R3, R4)
    function automatic bit model_match(input logic [1:0] f, input int i);
        if (!field_en[f]) return 1'b0;
        if (f == 2'd1) return i == 0;
        return i == int'(byte_sel);
    endfunction

    task automatic put_byte(input logic [1:0] f, input int i,
                            input logic [DATA_W-1:0] d, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_field = f;
        in_idx   = i[IDX_W-1:0];
        in_data  = d;
        e.data = d;
        if (model_pend && model_match(f, i)) begin
            e.data     = d ^ err_pat;
            model_pend = 1'b0;
        end
        e.fld = f;
        e.idx = i[IDX_W-1:0];
        e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_frame(input int plen, input int seed, input string req);
        for (int k = 0; k < 4; k++) put_byte(2'd0, k, 8'((seed * 7 + k) & 8'hff), req);
        for (int k = 0; k < plen; k++) put_byte(2'd1, k, 8'((seed * 13 + k * 3) & 8'hff), req);
        for (int k = 0; k < 4; k++) put_byte(2'd2, k, 8'((seed * 5 + k * 11) & 8'hff), req);
        for (int k = 0; k < 4; k++) put_byte(2'd3, k, 8'((seed * 3 + k * 17) & 8'hff), req);
        idle(1);
    endtask

    task automatic set_trig(input logic v);
        @(negedge clk);
        in_valid = 1'b0;
        if (v && !trig) model_pend = 1'b1;
        trig = v;
    endtask

    // Monitor: pop and compare one expected item per output beat
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R1", "unexpected beat", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(out_data == e.data, e.req, "data", int'(out_data), int'(e.data));
                chk(out_field == e.fld && out_idx == e.idx, "R1", "tag",
                    int'({out_field, out_idx}), int'({e.fld, e.idx}));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; in_field = '0; in_idx = '0;
        field_en = 4'b0000; byte_sel = 2'd0; err_pat = 8'h00; trig = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;

        // R1: pass-through, nothing armed
        field_en = 4'b1111; err_pat = 8'hff;
        send_frame(3, 1, "R1");

        // R3: core header, selector 2
        field_en = 4'b0001; byte_sel = 2'd2; err_pat = 8'h01;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(3, 2, "R3");

        // R4: payload, selector ignored
        field_en = 4'b0010; byte_sel = 2'd3; err_pat = 8'h80;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(5, 3, "R4");

        // R3 / R5: Ethernet FCS byte 1, then encapsulation FCS byte 3
        field_en = 4'b0100; byte_sel = 2'd1; err_pat = 8'h5a;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(2, 4, "R5");
        field_en = 4'b1000; byte_sel = 2'd3; err_pat = 8'hc3;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(2, 5, "R3");

        // R6: trigger held high over several frames
        field_en = 4'b0001; byte_sel = 2'd0; err_pat = 8'h10;
        set_trig(1'b1);
        send_frame(2, 6, "R6");
        send_frame(2, 7, "R6");
        send_frame(2, 8, "R6");

        // R7: drop and raise again
        set_trig(1'b0);
        set_trig(1'b1);
        send_frame(2, 9, "R7");
        set_trig(1'b0);

        // R8: several fields enabled, first in stream wins
        field_en = 4'b1101; byte_sel = 2'd1; err_pat = 8'h24;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(3, 10, "R8");

        // R9: zero pattern consumes, later nonzero pattern has no request
        field_en = 4'b0010; err_pat = 8'h00;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(2, 11, "R9");
        err_pat = 8'hee;
        send_frame(2, 12, "R9");

        // R10: pending across a frame with no enabled field
        field_en = 4'b0000; err_pat = 8'h42;
        set_trig(1'b1); set_trig(1'b0);
        send_frame(2, 13, "R10");
        field_en = 4'b0100; byte_sel = 2'd2;
        send_frame(2, 14, "R10");

        // R11: reset drops a pending request
        field_en = 4'b0001; byte_sel = 2'd0; err_pat = 8'h99;
        set_trig(1'b1); set_trig(1'b0);
        idle(3);
        rst = 1'b1; model_pend = 1'b0;
        idle(2);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        @(negedge clk); rst = 1'b0;
        send_frame(2, 15, "R11");

        idle(4);
        chk(q.size() == 0, "R1", "beats left in queue", q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule